// File: doc/BRIEF.md
# Programmable Interval Timer With Event Timestamp

This block counts down from a value that software loads and raises a sticky interrupt flag when the count runs out. In one-shot mode it stops at zero after a single expiry. In periodic mode it reloads the same value at expiry and flags every period, so a reload of N gives one tick every N clock cycles. A reload value of zero keeps the counter idle and never raises the flag.

Next to the interval counter runs a 64-bit time base that advances by one every clock cycle. A 32-bit count at tens of megahertz wraps within about a minute and a half, so the time base is 64 bits wide. An external event line is synchronized and edge-detected. On each rising edge the block copies the time base into a capture register, so software can tell when the event happened. Software reaches everything through a small word-wide register port. The read data is combinational from the address. The read strobe only triggers the side effects of a read.

Register offsets (word address `addr`): 0 control (bit 0 enable, bit 1 periodic), 1 reload value, 2 current count (read only), 3 status, 4 time base low word, 5 time base high word (latched), 6 capture low word, 7 capture high word. Status bit 0 is the interrupt flag and bit 2 is the capture overrun; both clear when written with 1. Status bit 1, capture valid, is read only.

Top module: `interval_timer`

## Requirements
- R1: After reset the control, reload, count and status registers read 0, `irq` is low, and the time base holds the parameter `TB_RST`.
- R2: Writing the control register with bit 0 set loads the count with the reload value. Writing it with bit 0 clear sets the count to 0. While enabled and nonzero, the count drops by one each cycle.
- R3: In one-shot mode (control bit 1 = 0), a reload of N sets the flag at the N-th clock edge after the start write. The count then stays at 0 and the flag is set only once.
- R4: In periodic mode (control bit 1 = 1), the count goes back to the reload value instead of 0. The flag sets at the N-th edge after start, and the count repeats N, N-1, ..., 1 without a gap.
- R5: The flag (status bit 0, also driven on `irq`) stays set until software writes status with bit 0 = 1. A write with bit 0 = 0 leaves it set. If an expiry and a clear fall in the same cycle, the flag stays set.
- R6: With a reload value of zero, starting in either mode leaves the count at 0 and never sets the flag.
- R7: The time base increases by exactly one every clock cycle after reset and carries across the 32-bit boundary.
- R8: A strobed read of offset 4 returns the low word and latches the high word at the same edge. Offset 5 then returns that latched high word, even after the live time base has carried.
- R9: The event input passes through a two-stage synchronizer. If it rises in the cycle whose time base is T, the capture register loads T+2 and status bit 1 sets.
- R10: A strobed read of offset 6 clears status bit 1. A rising event edge while bit 1 is set keeps the earlier capture and sets status bit 2. Writing status with bit 2 = 1 clears status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects only) |
| addr | input | 3 | Register word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| ev_in | input | 1 | Asynchronous external event line |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The hardest state to reach from the ports is a carry of the time base across the 32-bit boundary falling between the two halves of a software read. At one increment per cycle, that boundary would take billions of cycles from a zero start. The bench therefore overrides the reset value of the time base with a value just under the boundary. It reads the low word before the carry and the high word after it, then repeats the pair once the carry is past. A second hard case is an expiry and a flag clear landing on the same edge. The bench produces it with a periodic reload of one, where every edge is an expiry.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DATA_W = 32,
  parameter logic [2*DATA_W-1:0] TB_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_in,
  output logic              irq
);
  localparam int TB_W = 2 * DATA_W;

  logic              ctl_en, ctl_per, irq_flag;
  logic [DATA_W-1:0] reload_q, cnt, tb_hi_q;
  logic [TB_W-1:0]   tb, cap;
  logic              cap_valid, overrun;
  logic [2:0]        sync;

  wire wr_ctl   = wr_en && addr == 3'd0;
  wire wr_rld   = wr_en && addr == 3'd1;
  wire wr_sts   = wr_en && addr == 3'd3;
  wire rd_tblo  = rd_en && addr == 3'd4;
  wire rd_caplo = rd_en && addr == 3'd6;
  wire run      = ctl_en && cnt != '0;
  wire expire   = run && cnt == DATA_W'(1) && !wr_ctl;
  wire ev_edge  = sync[1] && !sync[2];
  wire cap_free = !cap_valid || rd_caplo;

  assign irq = irq_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_per  <= 1'b0;
      reload_q <= '0;
      cnt      <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_en  <= wdata[0];
        ctl_per <= wdata[1];
      end
      if (wr_rld) reload_q <= wdata;
      if (wr_ctl)      cnt <= wdata[0] ? reload_q : '0;
      else if (expire) cnt <= ctl_per ? reload_q : '0;
      else if (run)    cnt <= cnt - DATA_W'(1);
      irq_flag <= expire || (irq_flag && !(wr_sts && wdata[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb        <= TB_RST;
      tb_hi_q   <= '0;
      cap       <= '0;
      cap_valid <= 1'b0;
      overrun   <= 1'b0;
      sync      <= '0;
    end else begin
      tb   <= tb + TB_W'(1);
      sync <= {sync[1:0], ev_in};
      if (rd_tblo) tb_hi_q <= tb[TB_W-1:DATA_W];
      if (ev_edge && cap_free) begin
        cap       <= tb;
        cap_valid <= 1'b1;
      end else if (rd_caplo) begin
        cap_valid <= 1'b0;
      end
      overrun <= (ev_edge && !cap_free) || (overrun && !(wr_sts && wdata[2]));
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = DATA_W'({ctl_per, ctl_en});
      3'd1:    rdata = reload_q;
      3'd2:    rdata = cnt;
      3'd3:    rdata = DATA_W'({overrun, cap_valid, irq_flag});
      3'd4:    rdata = tb[DATA_W-1:0];
      3'd5:    rdata = tb_hi_q;
      3'd6:    rdata = cap[DATA_W-1:0];
      default: rdata = cap[TB_W-1:DATA_W];
    endcase
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt > DATA_W'(1) && !wr_ctl) |=> cnt == $past(cnt) - DATA_W'(1));
  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctl_per && cnt == DATA_W'(1) && !wr_ctl) |=> (cnt == '0 && irq));
  // R4
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctl_per && cnt == DATA_W'(1) && !wr_ctl) |=> (cnt == $past(reload_q) && irq));
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !wr_ctl) |=> cnt == '0);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_sts && wdata[0])) |=> irq);
  // R7
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> tb == $past(tb) + TB_W'(1));
  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !rd_caplo) |=> (cap == $past(cap) && cap_valid));
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TB_START = 64'h0000_0000_FFFF_FFD8;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, ev_in = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int          checks = 0, fails = 0;
  longint      cyc = 0;
  bit          done = 0;

  interval_timer #(.DATA_W(32), .TB_RST(TB_START)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_in(ev_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v, output longint at);
    addr = a; rd_en = 1; #1;
    v = rdata; at = cyc;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic ev_pulse();
    ev_in = 1; repeat (3) @(posedge clk); #1;
    ev_in = 0; repeat (3) @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] t;
    longint at, lo_at, ev_at;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;

    // R1 reset state
    addr = 0; #1; chk(rdata == 0, "R1 ctrl", rdata, 0);
    addr = 1; #1; chk(rdata == 0, "R1 reload", rdata, 0);
    addr = 2; #1; chk(rdata == 0, "R1 count", rdata, 0);
    addr = 3; #1; chk(rdata == 0, "R1 status", rdata, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    addr = 4; #1; t = TB_START + 64'(cyc);
    chk(rdata == t[31:0], "R1 time base start", rdata, t[31:0]);

    // R7 time base steps by one each cycle
    for (int i = 0; i < 5; i++) begin
      reg_rd(3'd4, v, at); t = TB_START + 64'(at);
      chk(v == t[31:0], "R7 time low", v, t[31:0]);
    end

    // R8 low read before carry, high read after carry
    reg_rd(3'd4, v, lo_at); t = TB_START + 64'(lo_at);
    chk(v == t[31:0], "R8 low word", v, t[31:0]);
    repeat (60) @(posedge clk); #1;
    reg_rd(3'd5, v, at);
    chk(v == t[63:32], "R8 latched high before carry", v, t[63:32]);
    reg_rd(3'd4, v, lo_at); t = TB_START + 64'(lo_at);
    chk(v == t[31:0], "R7 low after carry", v, t[31:0]);
    reg_rd(3'd5, v, at);
    chk(v == t[63:32] && v == 1, "R8 latched high after carry", v, t[63:32]);

    // R3 one-shot sweep
    for (int n = 1; n <= 6; n++) begin
      reg_wr(3'd1, 32'(n));
      reg_wr(3'd0, 32'h1);
      addr = 2;
      for (int i = 0; i <= n + 2; i++) begin
        if (i > 0) begin @(posedge clk); #1; end
        #1;
        chk(rdata == 32'((i < n) ? n - i : 0), "R2 R3 one-shot count", rdata, 32'((i < n) ? n - i : 0));
        chk(irq == (i >= n), "R3 one-shot flag", irq, 64'(i >= n));
      end
      reg_wr(3'd3, 32'h0);
      chk(irq == 1, "R5 write of zero keeps flag", irq, 1);
      reg_wr(3'd3, 32'h1);
      chk(irq == 0, "R5 clear flag", irq, 0);
      repeat (n + 2) @(posedge clk); #1;
      chk(irq == 0, "R3 single expiry only", irq, 0);
    end

    // R4 periodic sweep
    for (int n = 1; n <= 6; n++) begin
      reg_wr(3'd1, 32'(n));
      reg_wr(3'd0, 32'h3);
      addr = 2;
      for (int i = 0; i <= 3 * n; i++) begin
        if (i > 0) begin @(posedge clk); #1; end
        #1;
        chk(rdata == 32'(n - (i % n)), "R4 periodic count", rdata, 32'(n - (i % n)));
        chk(irq == (i >= n), "R4 periodic flag", irq, 64'(i >= n));
      end
      if (n == 1) begin
        reg_wr(3'd3, 32'h1);
        chk(irq == 1, "R5 expiry beats clear", irq, 1);
      end
      reg_wr(3'd0, 32'h0);
      addr = 2; #1;
      chk(rdata == 0, "R2 stop clears count", rdata, 0);
      reg_wr(3'd3, 32'h1);
      chk(irq == 0, "R5 clear after stop", irq, 0);
    end

    // R6 zero reload in both modes
    reg_wr(3'd1, 32'h0);
    for (int m = 1; m <= 3; m += 2) begin
      reg_wr(3'd0, 32'(m));
      repeat (20) @(posedge clk); #1;
      addr = 2; #1;
      chk(rdata == 0, "R6 count idle", rdata, 0);
      chk(irq == 0, "R6 no interrupt", irq, 0);
    end
    reg_wr(3'd0, 32'h0);

    // R9 capture sweep with varied gaps
    for (int k = 0; k < 4; k++) begin
      repeat (k * 3) @(posedge clk); #1;
      ev_at = cyc; t = TB_START + 64'(ev_at) + 64'd2;
      ev_pulse();
      reg_rd(3'd3, v, at);
      chk(v[1] == 1 && v[2] == 0, "R9 capture valid", 64'(v), 64'h2);
      reg_rd(3'd7, v, at);
      chk(v == t[63:32], "R9 capture high", v, t[63:32]);
      reg_rd(3'd6, v, at);
      chk(v == t[31:0], "R9 capture low", v, t[31:0]);
      reg_rd(3'd3, v, at);
      chk(v[1] == 0, "R10 read clears valid", 64'(v[1]), 0);
    end

    // R10 overrun keeps first capture
    ev_at = cyc; t = TB_START + 64'(ev_at) + 64'd2;
    ev_pulse();
    ev_pulse();
    reg_rd(3'd3, v, at);
    chk(v[2:1] == 2'b11, "R10 overrun set", 64'(v[2:1]), 64'h3);
    reg_rd(3'd6, v, at);
    chk(v == t[31:0], "R10 first capture kept", v, t[31:0]);
    reg_wr(3'd3, 32'h4);
    reg_rd(3'd3, v, at);
    chk(v[2] == 0, "R10 overrun cleared", 64'(v[2]), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule